// File: doc/BRIEF.md
# Transmit FIFO Frame Loader

This block takes an Ethernet frame that software places into a word-wide transmit FIFO and sends it out again as a byte stream. Software begins with a prefix word. Its two low bytes hold a 16-bit little-endian count of the frame bytes that follow the 14-byte Ethernet header. The upper two bytes of that same word hold the first two frame bytes. The remaining frame bytes follow, four to a word, in little-endian lane order. Software writes (frame length + 5) / 4 words in total, rounded down.

A write to the start strobe launches the frame. The strobe's readback bit, `pending`, stays high until the final byte has left the block, and software must not load a new frame before it falls. While the frame drains, the block presents it on a byte-wide valid/ready/last stream. Two options are captured at launch: one pads short frames with zero bytes up to 60 bytes, and one appends a CRC-32 frame check sequence. When the final byte has been accepted, a sticky FIFO-empty interrupt is raised. It stays high until software writes an acknowledge.

Top module: `txFrameLoader`

## Requirements
- R1: After reset, `pending`, `outValid` and `emptyIrq` are all 0.
- R2: Stream byte 0 is the low byte of the length field and stream byte 1 is its high byte. The frame length is the field value plus 14. Exactly that many frame bytes are presented, starting with stream byte 2.
- R3: Inside each 32-bit data word, bits [7:0] hold the earliest stream byte and bits [31:24] hold the latest, so stream byte k sits in word k/4, lane k%4.
- R4: `pending` is 1 from the clock edge that samples `startWr` until the edge that accepts the final output byte. It then returns to 0 on that same edge.
- R5: While `pending` is 1, data-word writes and further `startWr` pulses are ignored. The frame being sent is unchanged and is not restarted.
- R6: `outLast` is 1 on the final byte of a frame only, after any padding and any CRC bytes.
- R7: If `padEn` was 1 at launch and the frame is shorter than 60 bytes, zero bytes follow it up to a total of 60. Frames of 60 bytes or more, and all frames sent with `padEn` at 0, are not padded.
- R8: If `crcEn` was 1 at launch, four bytes follow the frame and any padding. They form the IEEE 802.3 CRC-32 of those bytes (reflected polynomial 0xEDB88320, initial value all ones, final inversion), sent least-significant byte first.
- R9: `emptyIrq` becomes 1 on the edge that accepts the final byte. It stays 1 until an edge on which `ackEmpty` is 1, and after that edge it reads 0.
- R10: If `ackEmpty` is 1 on the same edge that accepts a final byte, `emptyIrq` is set, not cleared.
- R11: While `outValid` is 1 and `outReady` is 0, `outData` and `outLast` hold their values and `outValid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataWrEn | input | 1 | Write strobe for one FIFO data word |
| dataWord | input | 32 | FIFO data word (prefix or packed frame bytes) |
| startWr | input | 1 | Start-bit write; launches the loaded frame |
| crcEn | input | 1 | Append CRC-32 to the frame (sampled at launch) |
| padEn | input | 1 | Pad short frames to 60 bytes (sampled at launch) |
| ackEmpty | input | 1 | Acknowledge write that clears the FIFO-empty interrupt |
| pending | output | 1 | Start-bit readback: a frame is being sent |
| emptyIrq | output | 1 | Sticky FIFO-empty interrupt |
| outData | output | 8 | Output byte |
| outValid | output | 1 | Output byte is valid |
| outLast | output | 1 | Output byte is the final byte of the frame |
| outReady | input | 1 | Downstream accepts the byte |

## Verification
The interrupt has two causes of change that can fall on the same edge: the drain of a frame sets it, and a software acknowledge clears it. To provoke the collision, the bench holds `ackEmpty` high for the whole of one frame, so the acknowledge is present on the edge that accepts the final byte. It then samples `emptyIrq` on the two negative edges that follow. It expects 1 on the first, because the set wins. It expects 0 on the second, because the acknowledge, still held, then takes effect.

// File: rtl/txl_pkg.sv
package txl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BODY,
    PH_PAD,
    PH_FCS
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       launch;   // frame start: rewind write pointer, seed CRC
    logic       crcStep;  // fold current data byte into CRC
    logic       padSel;   // present zero byte
    logic       fcsSel;   // present CRC byte
    logic [1:0] fcsLane;  // which CRC byte
  } dpCtrl_t;

  // one byte of reflected CRC-32, bit-serial form
  function automatic logic [31:0] crcNext(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/txl_ctrl.sv
module txl_ctrl
  import txl_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int HDR_LEN = 14,
  parameter int MIN_LEN = 60,
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  input  logic             crcEn,
  input  logic             padEn,
  input  logic             ackEmpty,
  input  logic             outReady,
  input  logic [LEN_W-1:0] lenField,
  output dpCtrl_t          ctl,
  output logic [CNT_W-1:0] byteIdx,
  output logic             outValid,
  output logic             outLast,
  output logic             pending,
  output logic             emptyIrq
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] frameLen;
  logic [1:0]       lane;
  logic             useCrc;
  logic             usePad;
  logic             fire;
  logic             wantPad;
  logic             bodyEnd;
  logic             padEnd;
  logic             fcsEnd;
  logic             finish;
  logic             launch;

  assign outValid = (phase != PH_IDLE);
  assign pending  = (phase != PH_IDLE);
  assign fire     = outValid && outReady;
  assign wantPad  = usePad && (frameLen < CNT_W'(MIN_LEN));
  assign bodyEnd  = (phase == PH_BODY) && (cnt == frameLen - CNT_W'(1));
  assign padEnd   = (phase == PH_PAD) && (cnt == CNT_W'(MIN_LEN - 1));
  assign fcsEnd   = (phase == PH_FCS) && (lane == 2'd3);
  assign outLast  = (bodyEnd && !wantPad && !useCrc) || (padEnd && !useCrc) || fcsEnd;
  assign finish   = fire && outLast;
  assign launch   = startWr && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      frameLen <= '0;
      lane     <= '0;
      useCrc   <= 1'b0;
      usePad   <= 1'b0;
    end else if (launch) begin
      phase    <= PH_BODY;
      cnt      <= '0;
      lane     <= '0;
      frameLen <= CNT_W'(lenField) + CNT_W'(HDR_LEN);
      useCrc   <= crcEn;
      usePad   <= padEn;
    end else if (fire) begin
      case (phase)
        PH_BODY: begin
          if (bodyEnd) begin
            if (wantPad) begin
              phase <= PH_PAD;
              cnt   <= cnt + CNT_W'(1);
            end else if (useCrc) begin
              phase <= PH_FCS;
              lane  <= '0;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_PAD: begin
          if (padEnd) begin
            phase <= useCrc ? PH_FCS : PH_IDLE;
            lane  <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_FCS: begin
          if (fcsEnd) phase <= PH_IDLE;
          else        lane  <= lane + 2'd1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // sticky interrupt: a drain on the same edge as an acknowledge wins
  always_ff @(posedge clk) begin
    if (!rstN)         emptyIrq <= 1'b0;
    else if (finish)   emptyIrq <= 1'b1;
    else if (ackEmpty) emptyIrq <= 1'b0;
  end

  always_comb begin
    ctl.launch  = launch;
    ctl.crcStep = fire && ((phase == PH_BODY) || (phase == PH_PAD));
    ctl.padSel  = (phase == PH_PAD);
    ctl.fcsSel  = (phase == PH_FCS);
    ctl.fcsLane = lane;
  end

  assign byteIdx = cnt;

endmodule

// File: rtl/txl_datapath.sv
module txl_datapath
  import txl_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  parameter int LEN_W       = 16,
  parameter int PREFIX      = 2,
  localparam int CNT_W      = LEN_W + 1,
  localparam int AW         = $clog2(DEPTH_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrEn,
  input  logic [31:0]      dataWord,
  input  logic             pending,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] byteIdx,
  output logic [LEN_W-1:0] lenField,
  output logic [7:0]       outData
);

  logic [31:0]      mem [DEPTH_WORDS];
  logic [AW:0]      wrPtr;
  logic             acceptWr;
  logic [CNT_W-1:0] streamAddr;
  logic [AW-1:0]    wordSel;
  logic [1:0]       laneSel;
  logic [7:0]       fifoByte;
  logic [7:0]       dataByte;
  logic [31:0]      crcReg;
  logic [31:0]      fcs;

  assign acceptWr = dataWrEn && !pending && !ctl.launch && (wrPtr < (AW+1)'(DEPTH_WORDS));

  always_ff @(posedge clk) begin
    if (!rstN)           wrPtr <= '0;
    else if (ctl.launch) wrPtr <= '0;
    else if (acceptWr)   wrPtr <= wrPtr + (AW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (acceptWr) mem[wrPtr[AW-1:0]] <= dataWord;
  end

  assign lenField   = mem[0][LEN_W-1:0];
  assign streamAddr = byteIdx + CNT_W'(PREFIX);
  assign wordSel    = AW'(streamAddr >> 2);
  assign laneSel    = streamAddr[1:0];
  assign fifoByte   = mem[wordSel][8*laneSel +: 8];
  assign dataByte   = ctl.padSel ? 8'h00 : fifoByte;

  always_ff @(posedge clk) begin
    if (!rstN)            crcReg <= '1;
    else if (ctl.launch)  crcReg <= '1;
    else if (ctl.crcStep) crcReg <= crcNext(crcReg, dataByte);
  end

  assign fcs     = ~crcReg;
  assign outData = ctl.fcsSel ? fcs[8*ctl.fcsLane +: 8] : dataByte;

endmodule

// File: rtl/txFrameLoader.sv
module txFrameLoader
  import txl_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  parameter int LEN_W       = 16,
  parameter int HDR_LEN     = 14,
  parameter int MIN_LEN     = 60,
  localparam int CNT_W      = LEN_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataWrEn,
  input  logic [31:0] dataWord,
  input  logic        startWr,
  input  logic        crcEn,
  input  logic        padEn,
  input  logic        ackEmpty,
  output logic        pending,
  output logic        emptyIrq,
  output logic [7:0]  outData,
  output logic        outValid,
  output logic        outLast,
  input  logic        outReady
);

  dpCtrl_t          ctl;
  logic [CNT_W-1:0] byteIdx;
  logic [LEN_W-1:0] lenField;

  txl_ctrl #(
    .LEN_W  (LEN_W),
    .HDR_LEN(HDR_LEN),
    .MIN_LEN(MIN_LEN)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startWr (startWr),
    .crcEn   (crcEn),
    .padEn   (padEn),
    .ackEmpty(ackEmpty),
    .outReady(outReady),
    .lenField(lenField),
    .ctl     (ctl),
    .byteIdx (byteIdx),
    .outValid(outValid),
    .outLast (outLast),
    .pending (pending),
    .emptyIrq(emptyIrq)
  );

  txl_datapath #(
    .DEPTH_WORDS(DEPTH_WORDS),
    .LEN_W      (LEN_W),
    .PREFIX     (2)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dataWrEn(dataWrEn),
    .dataWord(dataWord),
    .pending (pending),
    .ctl     (ctl),
    .byteIdx (byteIdx),
    .lenField(lenField),
    .outData (outData)
  );

endmodule

// File: rtl/txFrameLoader_chk.sv
module txFrameLoader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startWr,
  input logic       ackEmpty,
  input logic       pending,
  input logic       emptyIrq,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outLast,
  input logic       outReady
);

  // R11: a stalled byte is held
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R4: start while idle makes the frame pending
  a_r4_start_pends: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && !pending) |=> pending);

  // R4 and R9: accepting the final byte ends the frame and raises the interrupt
  a_r9_drain_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (emptyIrq && !pending));

  // R9: acknowledge without a drain clears the interrupt
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackEmpty && !(outValid && outReady && outLast)) |=> !emptyIrq);

  // R9: interrupt is sticky without acknowledge
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (emptyIrq && !ackEmpty) |=> emptyIrq);

  // R5: pending does not drop without a final byte being accepted
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !(outReady && outLast)) |=> pending);

endmodule

bind txFrameLoader txFrameLoader_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .startWr (startWr),
  .ackEmpty(ackEmpty),
  .pending (pending),
  .emptyIrq(emptyIrq),
  .outData (outData),
  .outValid(outValid),
  .outLast (outLast),
  .outReady(outReady)
);

// File: tb/txFrameLoader_tb_top.sv
module txFrameLoader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dataWrEn = 1'b0;
  logic [31:0] dataWord = '0;
  logic        startWr = 1'b0;
  logic        crcEn = 1'b0;
  logic        padEn = 1'b0;
  logic        ackEmpty = 1'b0;
  logic        pending;
  logic        emptyIrq;
  logic [7:0]  outData;
  logic        outValid;
  logic        outLast;
  logic        outReady = 1'b1;

  int total = 0;
  int bad = 0;
  logic [8:0] expQ[$];
  bit lastFired = 0;
  bit holdReady = 0;
  bit rndReady = 0;
  logic [15:0] lfsr = 16'hACE1;
  string curReq = "R2";
  logic [7:0] fb [0:1599];
  logic [7:0] sb [0:1603];

  always #5 clk = ~clk;

  txFrameLoader dut_i (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataWord(dataWord),
    .startWr(startWr), .crcEn(crcEn), .padEn(padEn), .ackEmpty(ackEmpty),
    .pending(pending), .emptyIrq(emptyIrq), .outData(outData),
    .outValid(outValid), .outLast(outLast), .outReady(outReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready driver, away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (holdReady) outReady = 1'b0;
    else if (rndReady) outReady = lfsr[3] | lfsr[7];
    else outReady = 1'b1;
  end

  // monitor: pop and compare each accepted byte
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk(0, {curReq, " extra byte"}, outData, 0);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        chk(outData == e[7:0], {curReq, " data"}, outData, e[7:0]);
        chk(outLast == e[8], "R6 last flag", outLast, e[8]);
      end
      if (outLast) lastFired = 1;
    end
  end

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic writeWord(input logic [31:0] w);
    @(posedge clk); #1;
    dataWrEn = 1'b1;
    dataWord = w;
    @(posedge clk); #1;
    dataWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1;
    startWr = 1'b1;
    @(posedge clk); #1;
    startWr = 1'b0;
  endtask

  task automatic sendFrame(input int n, input bit useCrc, input bit usePad,
                           input int seed, input bit stall, input bit collide, input string req);
    int lenv, nw, tot;
    logic [31:0] c;
    logic [7:0] ex [0:1603];
    curReq = req;
    lenv = n - 14;
    for (int k = 0; k < n; k++) fb[k] = 8'(seed + k * 13 + (k >> 3));
    sb[0] = lenv[7:0];
    sb[1] = lenv[15:8];
    for (int k = 0; k < n; k++) sb[k + 2] = fb[k];
    for (int k = n + 2; k < n + 6; k++) sb[k] = 8'h00;
    nw = (n + 5) / 4;
    // expected stream: frame, pad, crc
    tot = n;
    for (int k = 0; k < n; k++) ex[k] = fb[k];
    if (usePad && n < 60) begin
      for (int k = n; k < 60; k++) ex[k] = 8'h00;
      tot = 60;
    end
    c = 32'hFFFFFFFF;
    for (int k = 0; k < tot; k++) c = refCrc(c, ex[k]);
    c = ~c;
    if (useCrc) begin
      for (int k = 0; k < 4; k++) ex[tot + k] = c[8*k +: 8];
      tot = tot + 4;
    end
    for (int k = 0; k < tot; k++) expQ.push_back({(k == tot - 1), ex[k]});
    // load: little-endian lanes, R3
    for (int w = 0; w < nw; w++)
      writeWord({sb[4*w+3], sb[4*w+2], sb[4*w+1], sb[4*w]});
    crcEn = useCrc;
    padEn = usePad;
    if (stall) holdReady = 1;
    if (collide) ackEmpty = 1'b1;
    lastFired = 0;
    pulseStart();
    chk(pending == 1'b1, "R4 pending after start", pending, 1);
    crcEn = ~useCrc;
    padEn = ~usePad;
    if (stall) begin
      // R5: junk writes and a second start while pending
      writeWord(32'hDEADBEEF);
      writeWord(32'h5A5A5A5A);
      writeWord(32'h01234567);
      pulseStart();
      chk(pending == 1'b1, "R5 still pending", pending, 1);
      chk(outData == fb[0], "R5 first byte held", outData, fb[0]);
      holdReady = 0;
    end
    wait (lastFired);
    @(negedge clk);
    chk(pending == 1'b0, "R4 pending cleared", pending, 0);
    chk(emptyIrq == 1'b1, collide ? "R10 set wins" : "R9 irq set", emptyIrq, 1);
    chk(expQ.size() == 0, {req, " byte count"}, expQ.size(), 0);
    if (collide) begin
      @(negedge clk);
      chk(emptyIrq == 1'b0, "R10 ack then clears", emptyIrq, 0);
      ackEmpty = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
      chk(emptyIrq == 1'b1, "R9 irq sticky", emptyIrq, 1);
      ackEmpty = 1'b1;
      @(negedge clk);
      ackEmpty = 1'b0;
      chk(emptyIrq == 1'b0, "R9 ack clears", emptyIrq, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(pending == 1'b0, "R1 pending", pending, 0);
    chk(outValid == 1'b0, "R1 valid", outValid, 0);
    chk(emptyIrq == 1'b0, "R1 irq", emptyIrq, 0);

    sendFrame(20, 0, 0, 8'h10, 0, 0, "R2");
    sendFrame(23, 0, 0, 8'h33, 0, 0, "R3");
    rndReady = 1;
    sendFrame(64, 1, 1, 8'h71, 0, 0, "R8");
    sendFrame(14, 1, 1, 8'h02, 0, 0, "R7");
    sendFrame(59, 0, 1, 8'h45, 0, 0, "R7");
    sendFrame(60, 0, 1, 8'h99, 0, 0, "R7");
    sendFrame(30, 0, 0, 8'hC4, 0, 0, "R7");
    sendFrame(41, 1, 0, 8'hE0, 0, 0, "R8");
    rndReady = 0;
    sendFrame(17, 0, 0, 8'h5B, 1, 0, "R5");
    sendFrame(1514, 1, 0, 8'h21, 0, 0, "R2");
    sendFrame(25, 1, 1, 8'h66, 0, 1, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule